// File: doc/BRIEF.md
# Wake-up Message ID Filter

This block sits behind a low-frequency wake-up receiver and decides whether a received message should wake a sleeping host processor. Each time the receiver presents a decoded 16-bit message ID on a one-cycle strobe, the block compares it against two programmable IDs, the primary (high) ID and the secondary (low) ID. A 2-bit mode field picks the comparison: primary only, secondary only, either one, or no filtering at all. A matching message sets a match flag. A non-matching message is dropped silently unless the error interrupt is enabled. In that case it sets an error flag, which also wakes the host.

Software programs the block over a byte-wide register bus with registered reads. The same bus reaches a small auxiliary control byte. That byte holds a 3-bit auto-zero setting for the analog front end and a trim-edit gate. The gate decides whether two trim bytes may be written. The block has three reset inputs. Power-on reset and receiver soft reset return all state to its initial values. A third, general reset clears only the bus read register, so the programmed IDs and the settings survive it.

Top module: `lf_id_filter`

## Requirements
- R1: After power-on reset, reads return 0x00 from the four ID bytes (addresses 0 to 3), from the mode register (address 4) and from the flag register (address 5). They return 0x01 from the auxiliary register (address 6), so the auto-zero field in bits 2:0 is 001 and the trim-edit gate in bit 3 is 0. `host_wake` is 0 and `az_sel` is 001.
- R2: Addresses 0 and 1 hold the primary ID (0 = bits 15:8, 1 = bits 7:0). Addresses 2 and 3 hold the secondary ID in the same byte order. Each byte reads back the value last written to it, one cycle after the address is presented.
- R3: Mode register bits 1:0 select the filter: 00 = no filtering (every message matches), 01 = primary ID only, 10 = secondary ID only, 11 = either ID.
- R4: With match enable (mode bit 2) set to 1, a strobed ID that matches as selected sets the match flag (flag bit 0). The flag is set in the cycle after the strobe. `host_wake` rises one cycle after the flag. With match enable at 0, a match sets no flag.
- R5: With error enable (mode bit 3) at 0, a mismatch is ignored: neither flag changes and `host_wake` stays 0.
- R6: With error enable at 1, a mismatch sets the error flag (flag bit 1), and `host_wake` rises one cycle after the flag.
- R7: Both flags are write-1-to-clear at address 5. Each new message can only set flags and never clears one. If a new event and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: `host_wake` is (match flag AND match enable) OR (error flag AND error enable), registered. Clearing an enable drops the wake without clearing the flag.
- R9: Trim bytes at addresses 7 and 8 accept writes only while the trim-edit gate (auxiliary bit 3) is 1. While it is 0, writes leave them unchanged. Auxiliary bits 7:4 always read 0.
- R10: Receiver soft reset restores the same values as power-on reset (IDs 0x00, mode 0x00, flags 0x00, auxiliary 0x01, trim 0x00). The general reset changes no register and no flag, and only forces the read data to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| rx_soft_rst | input | 1 | Receiver soft reset, synchronous, active high |
| gen_rst | input | 1 | General reset; clears only the read data register |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| msg_valid | input | 1 | One-cycle strobe: a received ID is present |
| msg_id | input | 16 | Received message ID |
| host_wake | output | 1 | Registered wake / interrupt request to the host |
| az_sel | output | 3 | Auto-zero setting from the auxiliary register |
| trim_a | output | 8 | Trim byte A |
| trim_b | output | 8 | Trim byte B |

## Verification
A wrong mode decode or a corrupted ID byte shows up at the ports two cycles after the strobe. `host_wake` either rises when it should not or stays low, and a flag read one cycle later returns the wrong bit. A bad clear or set priority in the flag logic shows in the first flag read after the collision, before any later message can hide it. A trim byte written past a closed gate, or a register disturbed by the general reset, shows in the next read of that address. The bench therefore reads back every register it relies on after each stimulus.

// File: rtl/lf_idf_pkg.sv
`timescale 1ns/1ps
package lf_idf_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] A_ID0  = 4'd0;
  localparam logic [REG_AW-1:0] A_MODE = 4'd4;
  localparam logic [REG_AW-1:0] A_FLAG = 4'd5;
  localparam logic [REG_AW-1:0] A_AUX  = 4'd6;
  localparam logic [REG_AW-1:0] A_TRIM = 4'd7;

  localparam logic [REG_DW-1:0] AUX_RESET = 8'h01;

  typedef enum logic [1:0] {
    FILT_OFF = 2'b00,
    FILT_PRI = 2'b01,
    FILT_SEC = 2'b10,
    FILT_ANY = 2'b11
  } filt_mode_e;

  typedef struct packed {
    logic err;
    logic match;
  } flags_t;
endpackage

// File: rtl/lf_idf_regs.sv
`timescale 1ns/1ps
module lf_idf_regs
  import lf_idf_pkg::*;
#(
  parameter int unsigned ID_W   = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned N_TRIM = 2
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                gen_rst,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_we,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  flags_t              flags,
  output logic [ID_W-1:0]     id_pri,
  output logic [ID_W-1:0]     id_sec,
  output filt_mode_e          mode,
  output logic                match_en,
  output logic                err_en,
  output logic [2:0]          az_sel,
  output logic [N_TRIM*DW-1:0] trim_flat,
  output logic [1:0]          flag_w1c
);
  localparam int unsigned BPI    = ID_W / DW;
  localparam int unsigned N_IDB  = 2 * BPI;
  localparam int unsigned TRIM_B = A_TRIM;

  logic [DW-1:0] idb_q  [N_IDB];
  logic [DW-1:0] trim_q [N_TRIM];
  logic [3:0]    mode_q;
  logic [3:0]    aux_q;
  logic [DW-1:0] rd_mux;

  genvar gi;
  generate
    for (gi = 0; gi < N_IDB; gi++) begin : g_idb
      always_ff @(posedge clk) begin
        if (clr)
          idb_q[gi] <= '0;
        else if (bus_we && bus_addr == AW'(gi))
          idb_q[gi] <= bus_wdata;
      end
    end
    for (gi = 0; gi < BPI; gi++) begin : g_idpack
      assign id_pri[ID_W-1-gi*DW -: DW] = idb_q[gi];
      assign id_sec[ID_W-1-gi*DW -: DW] = idb_q[BPI+gi];
    end
    for (gi = 0; gi < N_TRIM; gi++) begin : g_trim
      always_ff @(posedge clk) begin
        if (clr)
          trim_q[gi] <= '0;
        else if (bus_we && aux_q[3] && bus_addr == AW'(TRIM_B + gi))
          trim_q[gi] <= bus_wdata;
      end
      assign trim_flat[gi*DW +: DW] = trim_q[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      mode_q <= '0;
      aux_q  <= AUX_RESET[3:0];
    end else if (bus_we) begin
      if (bus_addr == A_MODE) mode_q <= bus_wdata[3:0];
      if (bus_addr == A_AUX)  aux_q  <= bus_wdata[3:0];
    end
  end

  assign mode     = filt_mode_e'(mode_q[1:0]);
  assign match_en = mode_q[2];
  assign err_en   = mode_q[3];
  assign az_sel   = aux_q[2:0];
  assign flag_w1c = (bus_we && bus_addr == A_FLAG) ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_IDB; i++)
      if (bus_addr == AW'(i)) rd_mux = idb_q[i];
    for (int i = 0; i < N_TRIM; i++)
      if (bus_addr == AW'(TRIM_B + i)) rd_mux = trim_q[i];
    if (bus_addr == A_MODE) rd_mux = {{(DW-4){1'b0}}, mode_q};
    if (bus_addr == A_FLAG) rd_mux = {{(DW-2){1'b0}}, flags.err, flags.match};
    if (bus_addr == A_AUX)  rd_mux = {{(DW-4){1'b0}}, aux_q};
  end

  always_ff @(posedge clk) begin
    if (clr || gen_rst)
      bus_rdata <= '0;
    else
      bus_rdata <= rd_mux;
  end

  // R9
  trim_locked_chk: assert property (@(posedge clk) disable iff (clr)
    (bus_we && !aux_q[3] && bus_addr == AW'(TRIM_B)) |=> $stable(trim_q[0]));

  // R10
  gen_rst_rdata_chk: assert property (@(posedge clk) disable iff (clr)
    gen_rst |=> (bus_rdata == '0));
endmodule

// File: rtl/lf_idf_cmp.sv
`timescale 1ns/1ps
module lf_idf_cmp
  import lf_idf_pkg::*;
#(
  parameter int unsigned ID_W = 16
) (
  input  logic [ID_W-1:0] rx_id,
  input  logic [ID_W-1:0] id_pri,
  input  logic [ID_W-1:0] id_sec,
  input  filt_mode_e      mode,
  output logic            is_match,
  output logic            is_miss
);
  localparam int unsigned N_REF = 2;

  logic [ID_W-1:0]  ref_id [N_REF];
  logic [N_REF-1:0] hit;

  assign ref_id[0] = id_pri;
  assign ref_id[1] = id_sec;

  genvar gi;
  generate
    for (gi = 0; gi < N_REF; gi++) begin : g_cmp
      assign hit[gi] = (rx_id == ref_id[gi]);
    end
  endgenerate

  always_comb begin
    unique case (mode)
      FILT_OFF: is_match = 1'b1;
      FILT_PRI: is_match = hit[0];
      FILT_SEC: is_match = hit[1];
      FILT_ANY: is_match = |hit;
      default:  is_match = 1'b0;
    endcase
    is_miss = !is_match;
  end
endmodule

// File: rtl/lf_idf_flags.sv
`timescale 1ns/1ps
module lf_idf_flags
  import lf_idf_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       msg_valid,
  input  logic       is_match,
  input  logic       is_miss,
  input  logic       match_en,
  input  logic       err_en,
  input  logic [1:0] flag_w1c,
  output flags_t     flags,
  output logic       host_wake
);
  logic set_match, set_err;

  assign set_match = msg_valid && match_en && is_match;
  assign set_err   = msg_valid && err_en && is_miss;

  always_ff @(posedge clk) begin
    if (clr) begin
      flags     <= '0;
      host_wake <= 1'b0;
    end else begin
      flags.match <= (flags.match && !flag_w1c[0]) || set_match;
      flags.err   <= (flags.err   && !flag_w1c[1]) || set_err;
      host_wake   <= (flags.match && match_en) || (flags.err && err_en);
    end
  end

  // R5
  miss_ignored_chk: assert property (@(posedge clk) disable iff (clr)
    (msg_valid && is_miss && !err_en && flag_w1c == 2'b00) |=> $stable(flags));

  // R6
  err_needs_en_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(flags.err) |-> $past(err_en));

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (clr)
    (!match_en && !err_en) |=> !host_wake);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (clr)
    (msg_valid && match_en && is_match) |=> flags.match);
endmodule

// File: rtl/lf_id_filter.sv
`timescale 1ns/1ps
module lf_id_filter
  import lf_idf_pkg::*;
#(
  parameter int unsigned ID_W   = 16,
  parameter int unsigned DW     = REG_DW,
  parameter int unsigned AW     = REG_AW,
  parameter int unsigned N_TRIM = 2
) (
  input  logic            clk,
  input  logic            por_rst,
  input  logic            rx_soft_rst,
  input  logic            gen_rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_id,
  output logic            host_wake,
  output logic [2:0]      az_sel,
  output logic [DW-1:0]   trim_a,
  output logic [DW-1:0]   trim_b
);
  logic                 clr;
  logic [ID_W-1:0]      id_pri, id_sec;
  filt_mode_e           mode;
  logic                 match_en, err_en;
  logic [N_TRIM*DW-1:0] trim_flat;
  logic [1:0]           flag_w1c;
  flags_t               flags;
  logic                 is_match, is_miss;

  assign clr = por_rst || rx_soft_rst;

  lf_idf_regs #(.ID_W(ID_W), .DW(DW), .AW(AW), .N_TRIM(N_TRIM)) i_regs (
    .clk(clk), .clr(clr), .gen_rst(gen_rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flags(flags),
    .id_pri(id_pri), .id_sec(id_sec), .mode(mode),
    .match_en(match_en), .err_en(err_en), .az_sel(az_sel),
    .trim_flat(trim_flat), .flag_w1c(flag_w1c)
  );

  lf_idf_cmp #(.ID_W(ID_W)) i_cmp (
    .rx_id(msg_id), .id_pri(id_pri), .id_sec(id_sec), .mode(mode),
    .is_match(is_match), .is_miss(is_miss)
  );

  lf_idf_flags i_flags (
    .clk(clk), .clr(clr), .msg_valid(msg_valid),
    .is_match(is_match), .is_miss(is_miss),
    .match_en(match_en), .err_en(err_en), .flag_w1c(flag_w1c),
    .flags(flags), .host_wake(host_wake)
  );

  assign trim_a = trim_flat[0 +: DW];
  assign trim_b = trim_flat[DW +: DW];
endmodule

// File: tb/test_lf_id_filter.sv
`timescale 1ns/1ps
module test_lf_id_filter;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, rx_soft_rst = 1'b0, gen_rst = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        msg_valid = 1'b0;
  logic [15:0] msg_id = '0;
  logic        host_wake;
  logic [2:0]  az_sel;
  logic [7:0]  trim_a, trim_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lf_id_filter i_lf_id_filter (
    .clk(clk), .por_rst(por_rst), .rx_soft_rst(rx_soft_rst), .gen_rst(gen_rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_id(msg_id),
    .host_wake(host_wake), .az_sel(az_sel), .trim_a(trim_a), .trim_b(trim_b)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic send(input logic [15:0] id);
    msg_id = id; msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic load_ids();
    wr(4'd0, 8'hA5); wr(4'd1, 8'h5A);
    wr(4'd2, 8'h12); wr(4'd3, 8'h34);
  endtask

  // send a message, read flags (one more cycle), then check wake
  task automatic msg_case(input string req, input logic [15:0] id,
                          input logic [7:0] exp_flags, input logic exp_wake);
    send(id);
    rdchk(req, 4'd5, exp_flags);
    chk(req, {7'd0, host_wake}, {7'd0, exp_wake});
    wr(4'd5, 8'h03);
  endtask

  task automatic t_reset();
    rdchk("R1 id0", 4'd0, 8'h00);
    rdchk("R1 id3", 4'd3, 8'h00);
    rdchk("R1 mode", 4'd4, 8'h00);
    rdchk("R1 flags", 4'd5, 8'h00);
    rdchk("R1 aux", 4'd6, 8'h01);
    chk("R1 az_sel", {5'd0, az_sel}, 8'h01);
    chk("R1 wake", {7'd0, host_wake}, 8'h00);
  endtask

  task automatic t_idregs();
    load_ids();
    rdchk("R2 pri hi", 4'd0, 8'hA5);
    rdchk("R2 pri lo", 4'd1, 8'h5A);
    rdchk("R2 sec hi", 4'd2, 8'h12);
    rdchk("R2 sec lo", 4'd3, 8'h34);
  endtask

  task automatic t_modes();
    wr(4'd4, 8'h05); // pri only, match enabled
    msg_case("R3 R4 pri hit", 16'hA55A, 8'h01, 1'b1);
    msg_case("R3 R5 pri miss", 16'h1234, 8'h00, 1'b0);
    wr(4'd4, 8'h06); // sec only
    msg_case("R3 sec hit", 16'h1234, 8'h01, 1'b1);
    msg_case("R3 R5 sec miss", 16'hA55A, 8'h00, 1'b0);
    wr(4'd4, 8'h07); // either
    msg_case("R3 any pri", 16'hA55A, 8'h01, 1'b1);
    msg_case("R3 any sec", 16'h1234, 8'h01, 1'b1);
    msg_case("R3 R5 any miss", 16'h0000, 8'h00, 1'b0);
    wr(4'd4, 8'h04); // no filtering
    msg_case("R3 off", 16'hFFFF, 8'h01, 1'b1);
    wr(4'd4, 8'h01); // match enable off
    msg_case("R4 en off", 16'hA55A, 8'h00, 1'b0);
  endtask

  task automatic t_error();
    wr(4'd4, 8'h0D); // pri only, both enables
    msg_case("R6 err set", 16'h1234, 8'h02, 1'b1);
    wr(4'd4, 8'h09); // err enable only
    msg_case("R6 err only", 16'h0001, 8'h02, 1'b1);
  endtask

  task automatic t_sticky();
    wr(4'd4, 8'h0D);
    send(16'h1234);
    send(16'hA55A);
    rdchk("R7 both kept", 4'd5, 8'h03);
    wr(4'd5, 8'h02);
    rdchk("R7 w1c err", 4'd5, 8'h01);
    // clear and new match in the same cycle
    bus_addr = 4'd5; bus_wdata = 8'h01; bus_we = 1'b1;
    msg_id = 16'hA55A; msg_valid = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; msg_valid = 1'b0;
    rdchk("R7 set wins", 4'd5, 8'h01);
    wr(4'd5, 8'h03);
    rdchk("R7 w1c all", 4'd5, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(4'd4, 8'h05);
    send(16'hA55A);
    rd(4'd5, d);
    chk("R8 wake on", {7'd0, host_wake}, 8'h01);
    wr(4'd4, 8'h01);
    rd(4'd5, d);
    chk("R8 flag kept", d, 8'h01);
    chk("R8 wake gated", {7'd0, host_wake}, 8'h00);
    wr(4'd5, 8'h03);
  endtask

  task automatic t_trim();
    wr(4'd7, 8'h5A);
    rdchk("R9 locked a", 4'd7, 8'h00);
    chk("R9 locked port", trim_a, 8'h00);
    wr(4'd6, 8'hFD); // gate open, az=101, upper bits dropped
    rdchk("R9 aux", 4'd6, 8'h0D);
    chk("R9 az_sel", {5'd0, az_sel}, 8'h05);
    wr(4'd7, 8'h5A); wr(4'd8, 8'hC3);
    rdchk("R9 open a", 4'd7, 8'h5A);
    rdchk("R9 open b", 4'd8, 8'hC3);
    wr(4'd6, 8'h01);
    wr(4'd8, 8'h00);
    rdchk("R9 relocked", 4'd8, 8'hC3);
    chk("R9 trim_b", trim_b, 8'hC3);
  endtask

  task automatic t_resets();
    wr(4'd4, 8'h0D);
    send(16'h1234);
    bus_addr = 4'd0;
    @(negedge clk);
    gen_rst = 1'b1;
    @(negedge clk);
    gen_rst = 1'b0;
    chk("R10 gen rdata", bus_rdata, 8'h00);
    rdchk("R10 gen id", 4'd0, 8'hA5);
    rdchk("R10 gen mode", 4'd4, 8'h0D);
    rdchk("R10 gen flags", 4'd5, 8'h02);
    rdchk("R10 gen trim", 4'd7, 8'h5A);
    rx_soft_rst = 1'b1;
    @(negedge clk);
    rx_soft_rst = 1'b0;
    rdchk("R10 soft id", 4'd1, 8'h00);
    rdchk("R10 soft mode", 4'd4, 8'h00);
    rdchk("R10 soft flags", 4'd5, 8'h00);
    rdchk("R10 soft aux", 4'd6, 8'h01);
    rdchk("R10 soft trim", 4'd7, 8'h00);
    chk("R10 soft wake", {7'd0, host_wake}, 8'h00);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idregs();
    t_modes();
    t_error();
    t_sticky();
    t_gate();
    t_trim();
    t_resets();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule